// File: doc/BRIEF.md
# Boot-Time Configuration Chain Loader

This block fills a write-once configuration register from a serial boot ROM. It starts during hardware reset, once built-in self-test reports completion. It then asks the ROM for bits and accepts one bit on each cycle where the ROM raises its valid strobe. The ROM may stall as long as it needs.

Every load moves a fixed count of bits, `CHAIN_LEN`, and the first bit to arrive is the most significant. Only the last `USED_W` bits to arrive are kept as live configuration. The bits that arrive earlier are pushed off the far end of the chain and lost. Because of this, the ROM image always has the full allocated length, and the live bits end up in their places whatever the used width is.

After the load finishes, the configuration vector is frozen and the loader ignores its inputs until the next reset.

Top module: `cfgld_loader`

## Requirements
- R1: While reset is high, and on the first cycle after it, `load_done_o` and `rom_shift_req_o` are 0 and `cfg_o` is all zeros.
- R2: `rom_shift_req_o` rises in the cycle after `bist_done_i` is first sampled high following reset.
- R3: A bit is accepted only on a clock edge where both `rom_shift_req_o` and `rom_vld_i` are high. Stall cycles, where `rom_vld_i` is low, do not advance the load.
- R4: Exactly `CHAIN_LEN` bits are accepted per load. `load_done_o` rises in the cycle after the last accepted bit, and `rom_shift_req_o` is low from that cycle on.
- R5: Bits are numbered k = 0 to `CHAIN_LEN`-1 in arrival order. After the load, `cfg_o[j]` equals bit k = `CHAIN_LEN`-1-j. The first `CHAIN_LEN`-`USED_W` bits are discarded.
- R6: `cfg_o` reads all zeros for as long as `load_done_o` is low.
- R7: After `load_done_o` rises, `rom_vld_i`, `rom_bit_i` and `bist_done_i` have no effect: `cfg_o` is stable, `load_done_o` stays 1 and `rom_shift_req_o` stays 0.
- R8: A new reset clears the loader, and a fresh full-length load then works as it did the first time.
- R9: If `rom_vld_i` is high before `bist_done_i` has been seen, nothing is shifted and `rom_shift_req_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; re-arms the loader |
| bist_done_i | input | 1 | Self-test finished; starts the load |
| rom_bit_i | input | 1 | Serial data bit from the boot ROM |
| rom_vld_i | input | 1 | Data bit valid strobe from the ROM |
| cfg_o | output | USED_W | Parallel configuration vector, zero until loaded |
| rom_shift_req_o | output | 1 | Request to the ROM for the next bit |
| load_done_o | output | 1 | Load complete; holds until reset |

## Verification
Assertions check the following on every cycle:
- The bit counter stays in range, and stall cycles freeze both the counter and the chain.
- `load_done_o` follows the last accepted bit and never falls.
- The request and done flags are never high together.
- The configuration vector is frozen once loaded.

Only the bench's scenarios can show that bits land in their positions with the leading bits dropped. The bench does this across a sweep of data words and stall patterns on a short chain, plus one load at the full default length. The bench scenarios also show three things that no per-cycle property captures: strobes ahead of self-test are ignored, re-arming works after reset, and completion does not come one bit early.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_DONE  = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic en;
        logic din;
    } shift_cmd_t;

    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
    import cfgld_pkg::*;
#(
    parameter int CHAIN_LEN = 367
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bist_done_i,
    input  logic       bit_vld_i,
    input  logic       bit_i,
    output logic       shift_req_o,
    output shift_cmd_t cmd_o,
    output logic       done_o
);
    localparam int CNT_W = cnt_bits(CHAIN_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

    ld_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             at_last;

    assign shift_req_o = (state == LD_SHIFT);
    assign accept      = shift_req_o & bit_vld_i;
    assign at_last     = (cnt == LAST);
    assign done_o      = (state == LD_DONE);
    assign cmd_o       = '{en: accept, din: bit_i};

    always_comb begin
        state_nx = state;
        case (state)
            LD_IDLE:  if (bist_done_i) state_nx = LD_SHIFT;
            LD_SHIFT: if (accept && at_last) state_nx = LD_DONE;
            LD_DONE:  state_nx = LD_DONE;
            default:  state_nx = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LD_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (accept) cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == LD_SHIFT && !bit_vld_i) |=> ($stable(cnt) && state == LD_SHIFT));

    p_last_done_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && at_last) |=> done_o);

    p_idle_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (state == LD_IDLE && !bist_done_i) |=> !shift_req_o);

    p_write_once_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

endmodule

// File: rtl/cfgld_chain.sv
module cfgld_chain
    import cfgld_pkg::*;
#(
    parameter int USED_W = 304
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_cmd_t        cmd_i,
    output logic [USED_W-1:0] q_o
);
    logic [USED_W-1:0] sreg;

    generate
        if (USED_W == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)           sreg <= '0;
                else if (cmd_i.en) sreg <= cmd_i.din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)           sreg <= '0;
                else if (cmd_i.en) sreg <= {sreg[USED_W-2:0], cmd_i.din};
            end
        end
    endgenerate

    assign q_o = sreg;

    p_chain_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !cmd_i.en |=> $stable(sreg));

endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
    import cfgld_pkg::*;
#(
    parameter int CHAIN_LEN = 367,
    parameter int USED_W    = 304
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bist_done_i,
    input  logic              rom_bit_i,
    input  logic              rom_vld_i,
    output logic [USED_W-1:0] cfg_o,
    output logic              rom_shift_req_o,
    output logic              load_done_o
);
    shift_cmd_t        cmd;
    logic [USED_W-1:0] chain_q;
    logic              done;

    cfgld_ctrl #(.CHAIN_LEN(CHAIN_LEN)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .bist_done_i (bist_done_i),
        .bit_vld_i   (rom_vld_i),
        .bit_i       (rom_bit_i),
        .shift_req_o (rom_shift_req_o),
        .cmd_o       (cmd),
        .done_o      (done)
    );

    cfgld_chain #(.USED_W(USED_W)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .cmd_i (cmd),
        .q_o   (chain_q)
    );

    assign load_done_o = done;
    assign cfg_o       = done ? chain_q : '0;

    p_req_done_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(rom_shift_req_o && load_done_o));

    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (load_done_o && $past(load_done_o)) |-> $stable(cfg_o));

endmodule

// File: tb/cfgld_loader_test.sv
module cfgld_loader_test;
    localparam int SL = 12;
    localparam int SU = 8;
    localparam int DL = 367;
    localparam int DU = 304;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bist = 1'b0;
    logic s_bit = 1'b0, s_vld = 1'b0;
    logic d_bit = 1'b0, d_vld = 1'b0;
    logic [SU-1:0] s_cfg;
    logic [DU-1:0] d_cfg;
    logic s_req, s_done, d_req, d_done;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cfgld_loader #(.CHAIN_LEN(SL), .USED_W(SU)) uut (
        .clk(clk), .rst(rst), .bist_done_i(bist), .rom_bit_i(s_bit),
        .rom_vld_i(s_vld), .cfg_o(s_cfg), .rom_shift_req_o(s_req),
        .load_done_o(s_done));

    cfgld_loader u_full (
        .clk(clk), .rst(rst), .bist_done_i(bist), .rom_bit_i(d_bit),
        .rom_vld_i(d_vld), .cfg_o(d_cfg), .rom_shift_req_o(d_req),
        .load_done_o(d_done));

    task automatic chk(input logic ok, input string tag,
                       input logic [319:0] act, input logic [319:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic pat(input int k);
        return ((k * k + 3 * k) % 5) < 2;
    endfunction

    task automatic small_load(input logic [SL-1:0] w, input bit rearm);
        logic [SU-1:0] held;
        @(negedge clk); rst = 1'b1; s_vld = 1'b0; bist = 1'b0;
        @(negedge clk);
        chk(s_done == 0 && s_req == 0 && s_cfg == 0, "R1 reset state",
            {s_done, s_req, s_cfg}, 0);
        rst = 1'b0; s_vld = 1'b1; s_bit = 1'b1;
        @(negedge clk);
        chk(s_req == 0 && s_done == 0, "R1/R9 idle before self-test", s_req, 0);
        @(negedge clk);
        chk(s_cfg == 0 && s_req == 0, "R9 strobe before self-test ignored",
            {s_req, s_cfg}, 0);
        s_vld = 1'b0; bist = 1'b1;
        @(negedge clk);
        chk(s_req == 1, rearm ? "R8 R2 request after re-arm" : "R2 request after self-test",
            s_req, 1);
        bist = 1'b0;
        for (int i = 0; i < SL; i++) begin
            if ((int'(w) + i) % 3 == 0) begin
                s_vld = 1'b0;
                @(negedge clk);
            end
            s_vld = 1'b1; s_bit = w[SL-1-i];
            @(negedge clk);
            if (i == SL - 2)
                chk(s_done == 0 && s_cfg == 0, "R3/R6 not done one bit early",
                    {s_done, s_cfg}, 0);
        end
        s_vld = 1'b0;
        chk(s_done == 1 && s_req == 0, "R4 done after last bit", {s_done, s_req}, 2'b10);
        chk(s_cfg == w[SU-1:0], "R5 bit placement", s_cfg, w[SU-1:0]);
        held = s_cfg;
        for (int k = 0; k < 3; k++) begin
            s_vld = 1'b1; bist = 1'b1; s_bit = k[0];
            @(negedge clk);
            chk(s_cfg == held && s_done == 1 && s_req == 0, "R7 write-once",
                {s_done, s_req, s_cfg}, {2'b10, held});
        end
        s_vld = 1'b0; bist = 1'b0;
    endtask

    initial begin
        logic [DU-1:0] dexp;
        repeat (2) @(negedge clk);
        chk(d_done == 0 && d_cfg == 0 && d_req == 0, "R1 reset state full",
            {d_done, d_req, d_cfg}, 0);
        rst = 1'b0; bist = 1'b1;
        @(negedge clk);
        bist = 1'b0;
        chk(d_req == 1, "R2 full-length request", d_req, 1);
        for (int k = 0; k < DL; k++) begin
            if (k % 7 == 3) begin
                d_vld = 1'b0;
                @(negedge clk);
            end
            d_vld = 1'b1; d_bit = pat(k);
            @(negedge clk);
            if (k == DL - 2)
                chk(d_done == 0 && d_cfg == 0, "R6 full cfg blank before done",
                    {d_done, d_cfg}, 0);
        end
        d_vld = 1'b0;
        for (int j = 0; j < DU; j++) dexp[j] = pat(DL - 1 - j);
        chk(d_done == 1, "R4 full-length done", d_done, 1);
        chk(d_cfg == dexp, "R5 full-length placement", d_cfg, dexp);

        for (int w = 0; w < (1 << SL); w += 5)
            small_load(SL'(w), w != 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule